// File: doc/BRIEF.md
# Interrupt Vector Acknowledge Unit

This unit holds the pending hardware interrupt requests for four priority levels. Each level has up to 32 sources. When the processor acknowledges an interrupt, the unit returns the vector for that acknowledge. Sources raise their request bits through a raise vector. An acknowledge names a level. At a hardware level the unit takes the lowest-numbered pending source, clears that source's request bit in the same clock edge, and forms the vector from two values stored for that source: a default vector and a pattern of forced bits.

A separate memory-error flag has its own acknowledge level. Acknowledging that level returns a fixed vector and drops the flag. Any other level is outside the unit's range, and acknowledging it reports an error. A bus reset input clears every hardware request and leaves the stored vectors and the memory-error flag unchanged. A write port loads the per-source tables.

Top module: `vec_ack_unit`

## Requirements
- R1: Hardware levels are encoded 0x14 through 0x17 on `ack_lvl`, and levels 0x14 to 0x17 map to request rows 0 to 3. On an acknowledge at a hardware level, the source with the lowest-numbered pending bit in that row wins. One clock after `ack_stb`, `ack_vec` carries its vector and `ack_valid` is 1 for one cycle.
- R2: The winning request bit is cleared at the acknowledge edge and the other bits are kept. A second acknowledge at the same level therefore returns the next pending source.
- R3: The vector is (default | setbits) & (setbits | 0x1FC). Both values are the stored ones for the winning source.
- R4: If nothing is pending at the acknowledged hardware level, `ack_vec` is 0 and `ack_valid` is 1.
- R5: An acknowledge at level 0x1D returns vector 0x0060 with `ack_valid`, and clears `memerr_pending`.
- R6: An acknowledge at any level other than 0x14 to 0x17 or 0x1D gives `ack_err` = 1, `ack_valid` = 0 and `ack_vec` = 0 one clock later, and changes no request state.
- R7: `bus_reset` clears all request bits at all four levels, and it takes priority over a raise in the same cycle. It does not change `memerr_pending` or the tables.
- R8: A configuration write with `cfg_we` = 1 stores `cfg_data` for the source (`cfg_lvl`, `cfg_src`). `cfg_kind` = 0 selects the default vector and `cfg_kind` = 1 selects the set-bits pattern. Each entry is independent of the others.
- R9: After `rst_n` is low, `ack_valid`, `ack_err`, `ack_vec` and `memerr_pending` are 0, no requests are pending, and the table entries are 0.
- R10: A raise of the bit that is being cleared in the same cycle wins, so the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | Synchronous clear of all request bits |
| req_raise | input | 128 | One pulse per source sets its request bit; row r occupies bits r*32 to r*32+31 |
| memerr_raise | input | 1 | Sets the memory-error flag |
| cfg_we | input | 1 | Table write enable |
| cfg_kind | input | 1 | 0 selects the default vector, 1 selects the set-bits pattern |
| cfg_lvl | input | 2 | Row of the entry written |
| cfg_src | input | 5 | Source of the entry written |
| cfg_data | input | 16 | Value written |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_lvl | input | 5 | Level acknowledged |
| ack_vec | output | 16 | Vector formed |
| ack_valid | output | 1 | Vector valid, one cycle |
| ack_err | output | 1 | Level outside range, one cycle |
| memerr_pending | output | 1 | Memory-error flag |

## Verification
The hardest case to reach from the ports is a raise of a bit landing in the same edge as the acknowledge that clears it. The outcome only shows one acknowledge later, when that source wins a second time. The bench arranges this by driving the raise and the strobe together. It also loads tables in which the forced bits lie outside 0x1FC, so that the mask and the set-bit pattern show up separately. It confirms that an error-level acknowledge left the requests alone by acknowledging the real level afterwards.

// File: rtl/vec_ack_unit.sv
module vec_ack_unit #(
  parameter int NLVL = 4,
  parameter int NSRC = 32,
  parameter int VEC_W = 16,
  parameter int LVL_W = 5,
  parameter int HW_BASE = 20,
  parameter int MEMERR_LVL = 29,
  parameter logic [15:0] MEMERR_VEC = 16'h0060,
  parameter logic [15:0] VEC_MASK = 16'h01FC
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_reset,
  input  logic [NLVL*NSRC-1:0]        req_raise,
  input  logic                        memerr_raise,
  input  logic                        cfg_we,
  input  logic                        cfg_kind,
  input  logic [$clog2(NLVL)-1:0]     cfg_lvl,
  input  logic [$clog2(NSRC)-1:0]     cfg_src,
  input  logic [VEC_W-1:0]            cfg_data,
  input  logic                        ack_stb,
  input  logic [LVL_W-1:0]            ack_lvl,
  output logic [VEC_W-1:0]            ack_vec,
  output logic                        ack_valid,
  output logic                        ack_err,
  output logic                        memerr_pending
);
  localparam int NENT = NLVL * NSRC;
  localparam int SRC_W = $clog2(NSRC);
  localparam int LSEL_W = $clog2(NLVL);
  localparam int ENT_W = LSEL_W + SRC_W;
  localparam int HW_TOP = HW_BASE + NLVL - 1;
  localparam logic [VEC_W-1:0] MASK = VEC_W'(VEC_MASK);

  logic [NENT-1:0]   req_q;
  logic [VEC_W-1:0]  dvec_q [NENT];
  logic [VEC_W-1:0]  setb_q [NENT];
  logic              memerr_q;

  wire is_hw  = (ack_lvl >= LVL_W'(HW_BASE)) && (ack_lvl <= LVL_W'(HW_TOP));
  wire is_mem = (ack_lvl == LVL_W'(MEMERR_LVL));
  wire bad    = !is_hw && !is_mem;

  wire [LVL_W-1:0]  lvl_off = ack_lvl - LVL_W'(HW_BASE);
  wire [LSEL_W-1:0] row     = lvl_off[LSEL_W-1:0];
  wire [NSRC-1:0]   row_req = req_q[row*NSRC +: NSRC];

  logic             hit;
  logic [SRC_W-1:0] pick;
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (row_req[i]) begin
        hit  = 1'b1;
        pick = SRC_W'(i);
      end
  end

  wire [ENT_W-1:0] ent = {row, pick};
  wire [ENT_W-1:0] cfg_ent = {cfg_lvl, cfg_src};
  wire [VEC_W-1:0] formed = (dvec_q[ent] | setb_q[ent]) & (setb_q[ent] | MASK);
  wire             take = ack_stb && is_hw && hit;
  wire [NENT-1:0]  clr = take ? (NENT'(1) << ent) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         req_q <= '0;
    else if (bus_reset) req_q <= '0;
    else                req_q <= (req_q & ~clr) | req_raise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        dvec_q[e] <= '0;
        setb_q[e] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_kind) setb_q[cfg_ent] <= cfg_data;
      else          dvec_q[cfg_ent] <= cfg_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    memerr_q <= 1'b0;
    else if (memerr_raise)         memerr_q <= 1'b1;
    else if (ack_stb && is_mem)    memerr_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_vec   <= '0;
      ack_valid <= 1'b0;
      ack_err   <= 1'b0;
    end else begin
      ack_valid <= ack_stb && !bad;
      ack_err   <= ack_stb && bad;
      if (ack_stb)
        ack_vec <= is_mem ? VEC_W'(MEMERR_VEC) : (is_hw && hit) ? formed : '0;
    end

  assign memerr_pending = memerr_q;
endmodule

// File: rtl/vec_ack_unit_chk.sv
module vec_ack_unit_chk #(
  parameter int NLVL = 4,
  parameter int VEC_W = 16,
  parameter int LVL_W = 5,
  parameter int HW_BASE = 20,
  parameter int MEMERR_LVL = 29,
  parameter logic [15:0] MEMERR_VEC = 16'h0060
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_stb,
  input logic [LVL_W-1:0] ack_lvl,
  input logic             memerr_raise,
  input logic [VEC_W-1:0] ack_vec,
  input logic             ack_valid,
  input logic             ack_err,
  input logic             memerr_pending
);
  wire lvl_hw  = (ack_lvl >= LVL_W'(HW_BASE)) && (ack_lvl <= LVL_W'(HW_BASE + NLVL - 1));
  wire lvl_mem = (ack_lvl == LVL_W'(MEMERR_LVL));

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_valid && ack_err));
  assert_resp_needs_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb && lvl_hw |=> ack_valid);
  assert_err_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb && !lvl_hw && !lvl_mem |=> ack_err && ack_vec == '0);
  assert_memerr_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb && lvl_mem |=> ack_valid && ack_vec == VEC_W'(MEMERR_VEC));
  assert_memerr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb && lvl_mem && !memerr_raise |=> !memerr_pending);
  assert_no_idle_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_stb |=> !ack_valid && !ack_err);
endmodule

bind vec_ack_unit vec_ack_unit_chk #(
  .NLVL(NLVL), .VEC_W(VEC_W), .LVL_W(LVL_W), .HW_BASE(HW_BASE),
  .MEMERR_LVL(MEMERR_LVL), .MEMERR_VEC(MEMERR_VEC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .ack_lvl(ack_lvl),
  .memerr_raise(memerr_raise), .ack_vec(ack_vec), .ack_valid(ack_valid),
  .ack_err(ack_err), .memerr_pending(memerr_pending)
);

// File: tb/test_vec_ack_unit.sv
module test_vec_ack_unit;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         bus_reset = 0;
  logic [127:0] req_raise = '0;
  logic         memerr_raise = 0;
  logic         cfg_we = 0, cfg_kind = 0;
  logic [1:0]   cfg_lvl = 0;
  logic [4:0]   cfg_src = 0;
  logic [15:0]  cfg_data = 0;
  logic         ack_stb = 0;
  logic [4:0]   ack_lvl = 0;
  logic [15:0]  ack_vec;
  logic         ack_valid, ack_err, memerr_pending;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_ack_unit i_vec_ack_unit (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_raise(req_raise),
    .memerr_raise(memerr_raise), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_lvl(cfg_lvl), .cfg_src(cfg_src), .cfg_data(cfg_data),
    .ack_stb(ack_stb), .ack_lvl(ack_lvl), .ack_vec(ack_vec),
    .ack_valid(ack_valid), .ack_err(ack_err), .memerr_pending(memerr_pending));

  // {level, vector, valid, err, requirement}
  localparam logic [26:0] TBL [11] = '{
    {5'h14, 16'h0120, 1'b1, 1'b0, 4'd1},  // R1 lowest of bits 3,7
    {5'h14, 16'h01F0, 1'b1, 1'b0, 4'd2},  // R2 next source
    {5'h14, 16'h0000, 1'b1, 1'b0, 4'd4},  // R4 row empty
    {5'h15, 16'h0043, 1'b1, 1'b0, 4'd3},  // R3 low forced bits
    {5'h15, 16'h80C0, 1'b1, 1'b0, 4'd3},  // R3 high forced bit, bit 0 masked
    {5'h18, 16'h0000, 1'b0, 1'b1, 4'd6},  // R6 just above top
    {5'h16, 16'h0088, 1'b1, 1'b0, 4'd1},  // R1 row 2
    {5'h17, 16'h03FC, 1'b1, 1'b0, 4'd3},  // R3 bit 9 forced
    {5'h1D, 16'h0060, 1'b1, 1'b0, 4'd5},  // R5
    {5'h1F, 16'h0000, 1'b0, 1'b1, 4'd6},  // R6
    {5'h13, 16'h0000, 1'b0, 1'b1, 4'd6}   // R6 below base
  };

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg(logic [1:0] l, logic [4:0] s, logic k, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_lvl = l; cfg_src = s; cfg_kind = k; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic raise(logic [127:0] bits);
    @(negedge clk);
    req_raise = bits;
    @(negedge clk);
    req_raise = '0;
  endtask

  task automatic ack(logic [4:0] l);
    @(negedge clk);
    ack_stb = 1; ack_lvl = l;
    @(negedge clk);
    ack_stb = 0;
  endtask

  function automatic logic [127:0] bit_at(int r, int s);
    return 128'(1) << (r * 32 + s);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 valid", ack_valid, 0);
    chk("R9 err", ack_err, 0);
    chk("R9 vec", ack_vec, 0);
    chk("R9 memerr", memerr_pending, 0);
    ack(5'h14);
    chk("R9 empty after reset", {ack_valid, ack_vec}, {1'b1, 16'h0});

    // R8 table load
    cfg(0, 3, 0, 16'h0123);
    cfg(0, 7, 0, 16'h0FF0);
    cfg(1, 0, 0, 16'h0040); cfg(1, 0, 1, 16'h0003);
    cfg(1, 31, 0, 16'h00C1); cfg(1, 31, 1, 16'h8000);
    cfg(2, 1, 0, 16'h0088);
    cfg(3, 5, 0, 16'h01FC); cfg(3, 5, 1, 16'h0200);

    raise(bit_at(0, 7) | bit_at(0, 3) | bit_at(1, 31) | bit_at(1, 0) |
          bit_at(2, 1) | bit_at(3, 5));
    @(negedge clk); memerr_raise = 1; @(negedge clk); memerr_raise = 0;
    chk("R5 flag set", memerr_pending, 1);

    for (int i = 0; i < 11; i++) begin
      ack(TBL[i][26:22]);
      chk($sformatf("R%0d vec #%0d", TBL[i][3:0], i), ack_vec, TBL[i][21:6]);
      chk($sformatf("R%0d flags #%0d", TBL[i][3:0], i), {ack_valid, ack_err}, TBL[i][5:4]);
    end
    chk("R5 flag cleared", memerr_pending, 0);

    // R6 error ack leaves requests alone
    raise(bit_at(0, 3));
    ack(5'h1E);
    chk("R6 err", ack_err, 1);
    ack(5'h14);
    chk("R6 request kept", ack_vec, 16'h0120);

    // R8 entries independent: rewrite src 3 default only
    cfg(0, 3, 0, 16'h0154);
    raise(bit_at(0, 7) | bit_at(0, 3));
    ack(5'h14);
    chk("R8 rewritten entry", ack_vec, 16'h0154);
    ack(5'h14);
    chk("R8 neighbour untouched", ack_vec, 16'h01F0);

    // R10 raise beats clear in same edge
    raise(bit_at(2, 1));
    @(negedge clk);
    ack_stb = 1; ack_lvl = 5'h16; req_raise = bit_at(2, 1);
    @(negedge clk);
    ack_stb = 0; req_raise = '0;
    chk("R10 first", ack_vec, 16'h0088);
    ack(5'h16);
    chk("R10 still pending", ack_vec, 16'h0088);
    ack(5'h16);
    chk("R10 now empty", ack_vec, 16'h0000);

    // R7 bus reset clears all rows, not memerr
    raise(bit_at(0, 3) | bit_at(1, 0) | bit_at(2, 1) | bit_at(3, 5));
    @(negedge clk); memerr_raise = 1; @(negedge clk); memerr_raise = 0;
    @(negedge clk);
    bus_reset = 1; req_raise = bit_at(3, 5);
    @(negedge clk);
    bus_reset = 0; req_raise = '0;
    chk("R7 memerr kept", memerr_pending, 1);
    for (int l = 0; l < 4; l++) begin
      ack(5'(5'h14 + l));
      chk($sformatf("R7 row %0d cleared", l), {ack_valid, ack_vec}, {1'b1, 16'h0});
    end
    ack(5'h1D);
    chk("R5 memerr ack", ack_vec, 16'h0060);
    chk("R5 memerr low", memerr_pending, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule